// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

This block turns one fast source clock into two independently divided clock banks. A small source selector picks the clock that feeds both banks. In normal operation it is the oscillator clock from a PLL. In bypass it is a reference clock, which comes either from a crystal path or from a single-ended test clock. Each bank has a 2-bit select that chooses division by 1, 2, 4 or 5. The output keeps a 50% duty cycle in every mode, including the odd divide by 5. Bank A drives one true/complement pair and Bank B drives two pairs that carry the same clock.

An active-high divider reset holds every true output low and every complement high. The reset is synchronous to the selected source clock. Each bank has an enable. When the enable is low, the per-pair output-enable flags go low, and the pad stage outside this block places the pair in high impedance. A change of select or enable is applied only at a safe point, so an output never shows a runt pulse.

Top module: `dual_bank_divider`

## Requirements
- R1: The select code of a bank sets its divisor N: 2'b00 gives N=1 (the source clock passes through), 2'b01 gives N=2, 2'b10 gives N=4 and 2'b11 gives N=5. Each period lasts N source cycles and starts at a rising source edge. Within a period, the true output is high for the first N half source periods and low for the rest.
- R2: In divide by 5 the true output stays high for two and a half source cycles and low for two and a half, so the duty cycle is exactly 50%.
- R3: While the divider reset is sampled high, every true output is low and every complement output is high. The first rising source edge after reset is released starts a new period with the true output high.
- R4: A new select value is taken only at a rising edge where reset is high, or at the last source cycle of the current period. A change in the middle of a period has no effect until that period ends.
- R5: Each pair's output-enable flag is 1 when the pair is active. During reset the flag copies the bank enable at each rising edge. Otherwise it copies the bank enable only at a rising edge after which the true output stays low for the whole following source cycle; in divide by 1 it copies the enable at every rising edge.
- R6: Every complement output is the inverse of its true output. Both Bank B pairs carry identical levels.
- R7: When pll_en is 1, the oscillator clock drives both banks. When pll_en is 0, the crystal clock drives them if ref_is_xtal is 1 and the test clock drives them if it is 0. A clock that is not selected has no effect on the outputs.
- R8: The two banks divide independently, each by its own select, while both run from the same source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock from the PLL |
| xtal_clk | input | 1 | Reference clock from the crystal path |
| test_clk | input | 1 | Single-ended test reference clock |
| pll_en | input | 1 | 1: use the oscillator clock; 0: bypass to the reference |
| ref_is_xtal | input | 1 | Reference choice: 1 crystal, 0 test clock |
| div_rst | input | 1 | Active-high divider reset, synchronous to the selected source |
| sel_a | input | 2 | Bank A divisor code |
| sel_b | input | 2 | Bank B divisor code |
| en_a | input | 1 | Bank A output enable |
| en_b | input | 1 | Bank B output enable |
| qa | output | PAIRS_A | Bank A true outputs |
| qa_n | output | PAIRS_A | Bank A complement outputs |
| qa_oe | output | PAIRS_A | Bank A per-pair output enable |
| qb | output | PAIRS_B | Bank B true outputs |
| qb_n | output | PAIRS_B | Bank B complement outputs |
| qb_oe | output | PAIRS_B | Bank B per-pair output enable |

## Verification
The bench changes the select in the middle of a period, including moves into and out of divide by 1 and divide by 5. A divider that took the new code too early would shorten or stretch one period, and the reference model would catch it on that very half cycle. It toggles the enables at odd moments in every divisor. An enable that was applied at the wrong edge would cut a high phase or let one through, and the model, which predicts each flag edge by edge, would flag it. It also stops the chosen clock by selecting a clock that is not running, then resumes on each of the reference paths. A selector wired the wrong way would let the outputs keep toggling, or keep them frozen, when they should do the opposite. A reset applied while the half-cycle extension of divide by 5 is high would leave a stray high half cycle if that stage were not masked.

// File: rtl/dbd_pkg.sv
// Shared definitions for the dual-bank divider: divisor codes and the
// per-code counter limits. Assumes a counter wide enough for the largest
// divisor.
package dbd_pkg;

    localparam int CNT_W = 3;

    typedef enum logic [1:0] {
        DIV_1 = 2'b00,
        DIV_2 = 2'b01,
        DIV_4 = 2'b10,
        DIV_5 = 2'b11
    } div_code_e;

    // Last counter value of one output period.
    function automatic logic [CNT_W-1:0] last_count(input div_code_e code);
        case (code)
            DIV_1:   return CNT_W'(0);
            DIV_2:   return CNT_W'(1);
            DIV_4:   return CNT_W'(3);
            default: return CNT_W'(4);
        endcase
    endfunction

    // Number of whole source cycles the rising-edge stage holds high.
    function automatic logic [CNT_W-1:0] high_count(input div_code_e code);
        case (code)
            DIV_1:   return CNT_W'(0);
            DIV_2:   return CNT_W'(1);
            default: return CNT_W'(2);
        endcase
    endfunction

    // Odd divisors need the extra half cycle from the falling-edge stage.
    function automatic logic odd_div(input div_code_e code);
        return code == DIV_5;
    endfunction

endpackage

// File: rtl/dbd_src_mux.sv
// Source clock selector. It picks the oscillator clock, or in bypass one of
// two reference clocks. Assumes selects change only while the clocks that
// are involved are low or the dividers are in reset.
module dbd_src_mux (
    input  logic osc_clk,
    input  logic xtal_clk,
    input  logic test_clk,
    input  logic pll_en,
    input  logic ref_is_xtal,
    output logic src_clk
);

    logic ref_clk;

    // Reference choice between the crystal path and the test clock.
    always_comb ref_clk = ref_is_xtal ? xtal_clk : test_clk;

    // PLL path or bypass.
    always_comb src_clk = pll_en ? osc_clk : ref_clk;

endmodule

// File: rtl/dbd_divider.sv
// One bank's divider. A rising-edge counter gives the divided clock. For
// divide by 5, a falling-edge copy stretches the high phase by half a cycle
// to make it 50%. Divide by 1 gates the source through. The select is taken
// only in reset or at the last count. The enable flag updates only at edges
// after which the output stays low for a full source cycle.
module dbd_divider
    import dbd_pkg::*;
(
    input  logic       src_clk,
    input  logic       div_rst,
    input  logic [1:0] sel,
    input  logic       en,
    output logic       div_out,
    output logic       oe
);

    div_code_e        cur_sel;
    div_code_e        nxt_sel;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nxt_cnt;
    logic             rise_q;
    logic             fall_q;
    logic             run_q;
    logic             oe_q;
    logic             term;
    logic             nxt_rise;
    logic             oe_ok;

    // Next-state terms: end of period, new code, new count, new level.
    always_comb begin
        term     = (cnt == last_count(cur_sel));
        nxt_sel  = term ? div_code_e'(sel) : cur_sel;
        nxt_cnt  = term ? '0 : cnt + CNT_W'(1);
        nxt_rise = (nxt_cnt < high_count(nxt_sel));
        oe_ok    = (nxt_sel == DIV_1) ||
                   (!nxt_rise && (!odd_div(nxt_sel) || !rise_q));
    end

    // Rising-edge state: code, counter, level, run flag and enable flag.
    always_ff @(posedge src_clk) begin
        if (div_rst) begin
            cur_sel <= div_code_e'(sel);
            cnt     <= last_count(div_code_e'(sel));
            rise_q  <= 1'b0;
            run_q   <= 1'b0;
            oe_q    <= en;
        end else begin
            cur_sel <= nxt_sel;
            cnt     <= nxt_cnt;
            rise_q  <= nxt_rise;
            run_q   <= 1'b1;
            if (oe_ok) begin
                oe_q <= en;
            end
        end
    end

    // Falling-edge copy that adds the half cycle for odd divisors.
    always_ff @(negedge src_clk) begin
        fall_q <= rise_q;
    end

    // Output level: pass-through for divide by 1, otherwise the two stages.
    always_comb begin
        if (cur_sel == DIV_1) begin
            div_out = src_clk & run_q;
        end else begin
            div_out = run_q & (rise_q | (fall_q & odd_div(cur_sel)));
        end
    end

    // Enable flag to the pair stage.
    always_comb oe = oe_q;

endmodule

// File: rtl/dbd_pair_drv.sv
// Fans one divided clock out to PAIRS true/complement pairs, each with its
// own output-enable flag. Assumes the pad stage outside applies the tri-state.
module dbd_pair_drv #(
    parameter int PAIRS = 1
) (
    input  logic             div_in,
    input  logic             oe_in,
    output logic [PAIRS-1:0] q,
    output logic [PAIRS-1:0] q_n,
    output logic [PAIRS-1:0] oe
);

    // One true/complement pair and one enable flag for each output.
    for (genvar i = 0; i < PAIRS; i++) begin : g_pair
        assign q[i]   = div_in;
        assign q_n[i] = ~div_in;
        assign oe[i]  = oe_in;
    end

endmodule

// File: rtl/dual_bank_divider.sv
// Top of the dual-bank divider. One selected source clock feeds two banks,
// each with its own divisor code and enable. Assumes div_rst is held for at
// least one full source cycle whenever it is asserted.
module dual_bank_divider #(
    parameter int PAIRS_A = 1,
    parameter int PAIRS_B = 2
) (
    input  logic               osc_clk,
    input  logic               xtal_clk,
    input  logic               test_clk,
    input  logic               pll_en,
    input  logic               ref_is_xtal,
    input  logic               div_rst,
    input  logic [1:0]         sel_a,
    input  logic [1:0]         sel_b,
    input  logic               en_a,
    input  logic               en_b,
    output logic [PAIRS_A-1:0] qa,
    output logic [PAIRS_A-1:0] qa_n,
    output logic [PAIRS_A-1:0] qa_oe,
    output logic [PAIRS_B-1:0] qb,
    output logic [PAIRS_B-1:0] qb_n,
    output logic [PAIRS_B-1:0] qb_oe
);

    logic src_clk;
    logic div_a;
    logic div_b;
    logic oe_a;
    logic oe_b;

    dbd_src_mux u_mux (
        .osc_clk    (osc_clk),
        .xtal_clk   (xtal_clk),
        .test_clk   (test_clk),
        .pll_en     (pll_en),
        .ref_is_xtal(ref_is_xtal),
        .src_clk    (src_clk)
    );

    dbd_divider u_div_a (
        .src_clk(src_clk),
        .div_rst(div_rst),
        .sel    (sel_a),
        .en     (en_a),
        .div_out(div_a),
        .oe     (oe_a)
    );

    dbd_divider u_div_b (
        .src_clk(src_clk),
        .div_rst(div_rst),
        .sel    (sel_b),
        .en     (en_b),
        .div_out(div_b),
        .oe     (oe_b)
    );

    dbd_pair_drv #(.PAIRS(PAIRS_A)) u_drv_a (
        .div_in(div_a),
        .oe_in (oe_a),
        .q     (qa),
        .q_n   (qa_n),
        .oe    (qa_oe)
    );

    dbd_pair_drv #(.PAIRS(PAIRS_B)) u_drv_b (
        .div_in(div_b),
        .oe_in (oe_b),
        .q     (qb),
        .q_n   (qb_n),
        .oe    (qb_oe)
    );

endmodule

// File: rtl/dual_bank_divider_chk.sv
// Property checker for the dual-bank divider, bound to the top. It checks
// the reset output levels, how the enable flags follow the enables in reset,
// and that an enable flag changes only while the output is low.
module dual_bank_divider_chk #(
    parameter int PAIRS_A = 1,
    parameter int PAIRS_B = 2
) (
    input logic               src_clk,
    input logic               div_rst,
    input logic               en_a,
    input logic               en_b,
    input logic [PAIRS_A-1:0] qa,
    input logic [PAIRS_A-1:0] qa_n,
    input logic [PAIRS_A-1:0] qa_oe,
    input logic [PAIRS_B-1:0] qb,
    input logic [PAIRS_B-1:0] qb_n,
    input logic [PAIRS_B-1:0] qb_oe
);

    logic rst_q;
    logic ena_q;
    logic enb_q;

    // Remember reset and the enables at the last rising edge.
    always_ff @(posedge src_clk) begin
        rst_q <= div_rst;
        ena_q <= en_a;
        enb_q <= en_b;
    end

    // R3: after a reset edge the true outputs are low and the complements high.
    always @(negedge src_clk) begin
        if (rst_q === 1'b1) begin
            p_reset_levels_r3: assert (qa == '0 && qa_n == '1 && qb == '0 && qb_n == '1)
                else $error("reset output levels wrong");
        end
    end

    // R5: a reset edge copies each bank enable into its flags.
    always @(posedge src_clk) begin
        if (rst_q === 1'b1) begin
            p_oe_in_reset_r5: assert (qa_oe == {PAIRS_A{ena_q}} && qb_oe == {PAIRS_B{enb_q}})
                else $error("enable flag not loaded in reset");
        end
    end

    // R5: a Bank A flag change is followed by a low output.
    p_oe_quiet_a_r5: assert property (@(posedge src_clk) disable iff (div_rst)
        !$stable(qa_oe) |-> (qa == '0))
        else $error("bank A enable changed while output high");

    // R5: a Bank B flag change is followed by a low output.
    p_oe_quiet_b_r5: assert property (@(posedge src_clk) disable iff (div_rst)
        !$stable(qb_oe) |-> (qb == '0))
        else $error("bank B enable changed while output high");

endmodule

bind dual_bank_divider dual_bank_divider_chk #(
    .PAIRS_A(PAIRS_A),
    .PAIRS_B(PAIRS_B)
) u_chk (
    .src_clk(src_clk),
    .div_rst(div_rst),
    .en_a   (en_a),
    .en_b   (en_b),
    .qa     (qa),
    .qa_n   (qa_n),
    .qa_oe  (qa_oe),
    .qb     (qb),
    .qb_n   (qb_n),
    .qb_oe  (qb_oe)
);

// File: tb/sim_dual_bank_divider.sv
// Bench: a behavioural model that tracks the half-period position of each bank.
// It is compared after every source edge.
module sim_dual_bank_divider;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    int   pick = 0;              // which clock input carries clk: 0 osc, 1 xtal, 2 test
    logic osc_clk, xtal_clk, test_clk;
    assign osc_clk  = (pick == 0) & clk;
    assign xtal_clk = (pick == 1) & clk;
    assign test_clk = (pick == 2) & clk;

    logic       pll_en = 1'b1, ref_is_xtal = 1'b1, div_rst = 1'b1;
    logic [1:0] sel_a = 2'b01, sel_b = 2'b10;
    logic       en_a = 1'b1, en_b = 1'b1;
    logic [0:0] qa, qa_n, qa_oe;
    logic [1:0] qb, qb_n, qb_oe;

    dual_bank_divider u0 (
        .osc_clk(osc_clk), .xtal_clk(xtal_clk), .test_clk(test_clk),
        .pll_en(pll_en), .ref_is_xtal(ref_is_xtal), .div_rst(div_rst),
        .sel_a(sel_a), .sel_b(sel_b), .en_a(en_a), .en_b(en_b),
        .qa(qa), .qa_n(qa_n), .qa_oe(qa_oe),
        .qb(qb), .qb_n(qb_n), .qb_oe(qb_oe)
    );

    int    checks = 0, fails = 0;
    string tag = "R3";
    bit    chk_on = 1'b0;

    int m_sel [2] = '{1, 2};
    int m_c   [2] = '{0, 0};
    bit m_run [2] = '{1'b0, 1'b0};
    bit m_oe  [2] = '{1'b1, 1'b1};

    function automatic int ndiv(input int code);
        return (code == 0) ? 1 : (code == 1) ? 2 : (code == 2) ? 4 : 5;
    endfunction

    function automatic bit src_ok();
        return (pll_en && pick == 0) || (!pll_en && ref_is_xtal && pick == 1) ||
               (!pll_en && !ref_is_xtal && pick == 2);
    endfunction

    // Model step at each source rising edge.
    always @(posedge clk) begin
        if (src_ok()) begin
            for (int b = 0; b < 2; b++) begin
                int code_in;
                bit en_in;
                code_in = (b == 0) ? int'(sel_a) : int'(sel_b);
                en_in   = (b == 0) ? en_a : en_b;
                if (div_rst) begin
                    m_sel[b] = code_in;
                    m_c[b]   = ndiv(code_in) - 1;
                    m_run[b] = 1'b0;
                    m_oe[b]  = en_in;
                end else begin
                    m_run[b] = 1'b1;
                    if (m_c[b] == ndiv(m_sel[b]) - 1) begin
                        m_sel[b] = code_in;
                        m_c[b]   = 0;
                    end else begin
                        m_c[b] = m_c[b] + 1;
                    end
                    if (ndiv(m_sel[b]) == 1 || 2 * m_c[b] >= ndiv(m_sel[b]))
                        m_oe[b] = en_in;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", rq, what, act, exp, $time);
        end
    endtask

    task automatic sample(input bit second_half);
        for (int b = 0; b < 2; b++) begin
            int hp;
            bit eq;
            hp = (second_half || !src_ok()) ? 2 * m_c[b] + 1 : 2 * m_c[b];
            eq = m_run[b] && (hp < ndiv(m_sel[b]));
            if (b == 0) begin
                chk(qa[0] === eq, tag, "qa level", int'(qa[0]), int'(eq));
                chk(qa_n[0] === !eq, "R6", "qa_n level", int'(qa_n[0]), int'(!eq));
                chk(qa_oe[0] === m_oe[0], "R5", "qa_oe", int'(qa_oe[0]), int'(m_oe[0]));
            end else begin
                for (int p = 0; p < 2; p++) begin
                    chk(qb[p] === eq, tag, "qb level", int'(qb[p]), int'(eq));
                    chk(qb_n[p] === !eq, "R6", "qb_n level", int'(qb_n[p]), int'(!eq));
                    chk(qb_oe[p] === m_oe[1], "R5", "qb_oe", int'(qb_oe[p]), int'(m_oe[1]));
                end
                chk(qb[0] === qb[1], "R6", "qb pair match", int'(qb[0]), int'(qb[1]));
            end
        end
    endtask

    // Compare in the middle of each half source period.
    always @(posedge clk) begin
        #2;
        if (chk_on) sample(1'b0);
    end
    always @(negedge clk) begin
        #2;
        if (chk_on) sample(1'b1);
    end

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_neg(2);
        chk_on = 1'b1;                               // R3: reset levels
        wait_neg(3);
        div_rst = 1'b0; tag = "R1";                  // divide by 2 and by 4
        wait_neg(24);
        tag = "R4"; sel_a = 2'b11; wait_neg(3);      // mid-period select changes
        sel_b = 2'b00; wait_neg(10);
        tag = "R2"; wait_neg(20);                    // divide by 5 duty
        tag = "R5"; en_a = 1'b0; wait_neg(7);        // enables at odd moments
        en_b = 1'b0; wait_neg(9);
        en_a = 1'b1; wait_neg(3); en_b = 1'b1; wait_neg(6);
        tag = "R8"; sel_a = 2'b00; sel_b = 2'b11; wait_neg(20);
        sel_a = 2'b10; wait_neg(3); sel_b = 2'b01; wait_neg(16);
        tag = "R7"; pick = 1; wait_neg(8);           // unselected clock: frozen
        pll_en = 1'b0; wait_neg(20);                 // bypass via crystal
        pick = 2; ref_is_xtal = 1'b0; wait_neg(20);  // bypass via test clock
        pick = 0; pll_en = 1'b1; wait_neg(10);
        tag = "R3"; div_rst = 1'b1; sel_a = 2'b11; sel_b = 2'b00; en_a = 1'b0;
        wait_neg(4);
        div_rst = 1'b0; en_a = 1'b1; tag = "R2"; wait_neg(25);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        checks++;
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule